// File: doc/BRIEF.md
# Converter Configuration Register and Channel Sequencer

This block is the digital control core that sits beside a multichannel analog-to-digital converter. A host shifts a 14-bit configuration word into it one bit per serial strobe, most significant bit first. The word is held aside and becomes active only when the next conversion starts. The word is dropped if it is incomplete when that conversion starts. The analog multiplexer and the conversion engine are outside the block. The block only tells them which input to sample next and learns when a conversion is finished.

At each conversion start the block picks the input for that conversion. It can use one fixed channel, or it can step through channels 0 up to a programmed last channel and then wrap. A temperature-sensor slot can follow the last channel. A separate write mode changes the other settings while the scan keeps its place. The block also returns a readback word, which is the configuration that governed the conversion that has just ended.

Top module: `conv_cfg_sequencer`

## Requirements
- R1: After reset, chan_sel is 0, temp_sel is 0 and cfg_readback equals DEFAULT_CFG (default 0x0380: last channel 7, sequencer off, fixed channel 0).
- R2: Word layout: bits [2:0] fixed channel, bits [4:3] sequencer mode, bits [9:7] last scanned channel, bits [13:10] and [6:5] other settings stored unchanged. Bits arrive MSB first, one per cfg_bit_vld cycle, and a complete word takes effect at the next conv_start.
- R3: If fewer than 14 strobes arrived when conv_start is seen, the partial word is discarded and the old configuration stays. Strobes beyond the 14th are ignored. The bit count clears at every conv_start.
- R4: In mode 2'b00 (off), every conversion uses the fixed channel with temp_sel 0.
- R5: In mode 2'b11 (channels only), successive conversions use channels 0, 1, ..., last, then 0 again.
- R6: In mode 2'b10 (channels then temperature), the last channel is followed by one temperature slot (temp_sel 1, chan_sel 0), then channel 0.
- R7: A complete write selecting mode 2'b10 or 2'b11 makes the conversion it is committed at use channel 0.
- R8: A complete write with mode 2'b01 keeps the active mode and the scan position and updates all other fields. If the kept position exceeds the new last channel, the next conversion uses channel 0.
- R9: On conv_done, cfg_readback takes the configuration used by that conversion. Otherwise it holds, so during a write it still shows the previous conversion's configuration.
- R10: chan_sel and temp_sel change only on the clock edge that samples conv_start, and they hold between starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bit_vld | input | 1 | One-cycle strobe per serial clock rising edge |
| cfg_bit | input | 1 | Serial configuration data bit |
| conv_start | input | 1 | Conversion start pulse |
| conv_done | input | 1 | Conversion complete pulse |
| chan_sel | output | 3 | Input channel for the current conversion |
| temp_sel | output | 1 | Current conversion samples the temperature sensor |
| cfg_readback | output | 14 | Configuration in force for the last finished conversion |

## Verification
A corrupt scan pointer shows as a wrong chan_sel or temp_sel on the very next conversion start, and it keeps propagating through the wrap order. So every start in a scan is compared. A bad bit counter or shift order shows one conversion later as a wrong readback word or as a partial word wrongly taking effect. The update-during-scan mode is checked with a pointer that the new last channel overtakes, where a lost position would first appear.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int CFG_W    = 14;
  localparam int CH_W     = 3;
  localparam int MODE_W   = 2;
  localparam int CNT_W    = $clog2(CFG_W + 1);
  localparam int FIX_LSB  = 0;
  localparam int MODE_LSB = 3;
  localparam int LAST_LSB = 7;

  typedef enum logic [MODE_W-1:0] {
    SEQ_OFF = 2'b00,
    SEQ_UPD = 2'b01,
    SEQ_CHT = 2'b10,
    SEQ_CH  = 2'b11
  } seq_mode_e;

  function automatic logic [CH_W-1:0] f_fixed(input logic [CFG_W-1:0] w);
    return w[FIX_LSB +: CH_W];
  endfunction

  function automatic logic [CH_W-1:0] f_last(input logic [CFG_W-1:0] w);
    return w[LAST_LSB +: CH_W];
  endfunction

  function automatic seq_mode_e f_mode(input logic [CFG_W-1:0] w);
    return seq_mode_e'(w[MODE_LSB +: MODE_W]);
  endfunction
endpackage

// File: rtl/cfgseq_shifter.sv
module cfgseq_shifter
  import cfgseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             conv_start,
  output logic [CFG_W-1:0] word,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);

  logic [CFG_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (conv_start) begin
      cnt_d = '0;
    end else if (bit_vld && (cnt_q < CNT_FULL)) begin
      sh_d  = {sh_q[CFG_W-2:0], bit_in};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign word = sh_q;
  assign full = (cnt_q == CNT_FULL);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  a_r3_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (cnt_q == '0));
endmodule

// File: rtl/cfgseq_store.sv
module cfgseq_store
  import cfgseq_pkg::*;
#(
  parameter logic [CFG_W-1:0] DEFAULT_CFG = 14'h0380
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             conv_done,
  input  logic             full,
  input  logic [CFG_W-1:0] word,
  output logic [CFG_W-1:0] cfg_eff,
  output logic             restart,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] rb_q
);
  logic [CFG_W-1:0] rb_d;
  seq_mode_e        new_mode;

  assign new_mode = f_mode(word);

  always_comb begin
    cfg_eff = cfg_q;
    restart = 1'b0;
    if (conv_start && full) begin
      cfg_eff = word;
      if (new_mode == SEQ_UPD) begin
        cfg_eff[MODE_LSB +: MODE_W] = cfg_q[MODE_LSB +: MODE_W];
      end else begin
        restart = (new_mode == SEQ_CH) || (new_mode == SEQ_CHT);
      end
    end
  end

  always_comb begin
    rb_d = rb_q;
    if (conv_done) rb_d = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= DEFAULT_CFG;
      rb_q  <= DEFAULT_CFG;
    end else begin
      cfg_q <= cfg_eff;
      rb_q  <= rb_d;
    end
  end

  a_r2_commit_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |=> $stable(cfg_q));
  a_r9_readback_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(rb_q));
  a_r8_mode_never_update: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (f_mode(cfg_q) != SEQ_UPD));
endmodule

// File: rtl/cfgseq_scan.sv
module cfgseq_scan
  import cfgseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             restart,
  input  logic [CFG_W-1:0] cfg_eff,
  input  logic [CFG_W-1:0] cfg_q,
  output logic [CH_W-1:0]  chan_sel,
  output logic             temp_sel
);
  logic [CH_W-1:0] cur_ch_q, cur_ch_d, nxt_ch_q, nxt_ch_d;
  logic            cur_tmp_q, cur_tmp_d, nxt_tmp_q, nxt_tmp_d;
  logic [CH_W-1:0] slot_ch, last;
  logic            slot_tmp;
  seq_mode_e       mode;

  assign mode = f_mode(cfg_eff);
  assign last = f_last(cfg_eff);

  always_comb begin
    if (mode == SEQ_OFF) begin
      slot_ch  = f_fixed(cfg_eff);
      slot_tmp = 1'b0;
    end else if (restart) begin
      slot_ch  = '0;
      slot_tmp = 1'b0;
    end else if (nxt_tmp_q && (mode == SEQ_CHT)) begin
      slot_ch  = '0;
      slot_tmp = 1'b1;
    end else if (nxt_tmp_q || (nxt_ch_q > last)) begin
      slot_ch  = '0;
      slot_tmp = 1'b0;
    end else begin
      slot_ch  = nxt_ch_q;
      slot_tmp = 1'b0;
    end
  end

  always_comb begin
    cur_ch_d  = cur_ch_q;
    cur_tmp_d = cur_tmp_q;
    nxt_ch_d  = nxt_ch_q;
    nxt_tmp_d = nxt_tmp_q;
    if (conv_start) begin
      cur_ch_d  = slot_ch;
      cur_tmp_d = slot_tmp;
      if ((mode == SEQ_OFF) || slot_tmp) begin
        nxt_ch_d  = '0;
        nxt_tmp_d = 1'b0;
      end else if (slot_ch == last) begin
        nxt_ch_d  = '0;
        nxt_tmp_d = (mode == SEQ_CHT);
      end else begin
        nxt_ch_d  = slot_ch + 1'b1;
        nxt_tmp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ch_q  <= '0;
      cur_tmp_q <= 1'b0;
      nxt_ch_q  <= '0;
      nxt_tmp_q <= 1'b0;
    end else begin
      cur_ch_q  <= cur_ch_d;
      cur_tmp_q <= cur_tmp_d;
      nxt_ch_q  <= nxt_ch_d;
      nxt_tmp_q <= nxt_tmp_d;
    end
  end

  assign chan_sel = cur_ch_q;
  assign temp_sel = cur_tmp_q;

  a_r4_fixed_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (f_mode(cfg_q) == SEQ_OFF) |-> (chan_sel == f_fixed(cfg_q) && !temp_sel));
  a_r6_temp_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    temp_sel |-> (f_mode(cfg_q) == SEQ_CHT && chan_sel == '0));
  a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (f_mode(cfg_q) != SEQ_OFF) |-> (chan_sel <= f_last(cfg_q)));
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && restart) |=> (chan_sel == '0 && !temp_sel));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |=> ($stable(chan_sel) && $stable(temp_sel)));
endmodule

// File: rtl/conv_cfg_sequencer.sv
module conv_cfg_sequencer
  import cfgseq_pkg::*;
#(
  parameter logic [CFG_W-1:0] DEFAULT_CFG = 14'h0380
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bit_vld,
  input  logic             cfg_bit,
  input  logic             conv_start,
  input  logic             conv_done,
  output logic [CH_W-1:0]  chan_sel,
  output logic             temp_sel,
  output logic [CFG_W-1:0] cfg_readback
);
  logic             rst_meta_q, rst_sync_q;
  logic [CFG_W-1:0] word, cfg_eff, cfg_q;
  logic             full, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfgseq_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .bit_vld    (cfg_bit_vld),
    .bit_in     (cfg_bit),
    .conv_start (conv_start),
    .word       (word),
    .full       (full)
  );

  cfgseq_store #(.DEFAULT_CFG(DEFAULT_CFG)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .full       (full),
    .word       (word),
    .cfg_eff    (cfg_eff),
    .restart    (restart),
    .cfg_q      (cfg_q),
    .rb_q       (cfg_readback)
  );

  cfgseq_scan u_scan (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .conv_start (conv_start),
    .restart    (restart),
    .cfg_eff    (cfg_eff),
    .cfg_q      (cfg_q),
    .chan_sel   (chan_sel),
    .temp_sel   (temp_sel)
  );
endmodule

// File: tb/tb_conv_cfg_sequencer.sv
`timescale 1ns/1ps
module tb_conv_cfg_sequencer;
  logic        clk = 1'b0;
  logic        rst_n, cfg_bit_vld, cfg_bit, conv_start, conv_done;
  logic [2:0]  chan_sel;
  logic        temp_sel;
  logic [13:0] cfg_readback;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit fin = 1'b0;

  typedef struct {
    int          due;
    bit          is_rb;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_cfg_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cfg_bit_vld(cfg_bit_vld), .cfg_bit(cfg_bit),
    .conv_start(conv_start), .conv_done(conv_done), .chan_sel(chan_sel),
    .temp_sel(temp_sel), .cfg_readback(cfg_readback)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      if (it.is_rb) chk({2'b00, cfg_readback}, it.exp, it.req);
      else          chk({12'h000, temp_sel, chan_sel}, it.exp, it.req);
    end
  end

  function automatic logic [13:0] mk(input logic [3:0] oth, input logic [2:0] last,
                                     input logic [1:0] b65, input logic [1:0] md,
                                     input logic [2:0] fx);
    return {oth, last, b65, md, fx};
  endfunction

  task automatic push(input bit is_rb, input logic [15:0] exp, input string req);
    item_t it;
    it.due = cyc + 1; it.is_rb = is_rb; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_bit_vld = 1'b1;
      cfg_bit     = v[15-i];
    end
    @(negedge clk);
    cfg_bit_vld = 1'b0;
  endtask

  task automatic conv(input logic [2:0] ch, input logic tmp, input string req);
    @(negedge clk);
    conv_start = 1'b1;
    push(1'b0, {12'h000, tmp, ch}, req);
    @(negedge clk);
    conv_start = 1'b0;
    conv_done  = 1'b1;
    @(negedge clk);
    conv_done  = 1'b0;
  endtask

  task automatic exp_rb(input logic [13:0] w, input string req);
    @(negedge clk);
    push(1'b1, {2'b00, w}, req);
    @(negedge clk);
  endtask

  task automatic exp_sel(input logic [2:0] ch, input logic tmp, input string req);
    @(negedge clk);
    push(1'b0, {12'h000, tmp, ch}, req);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_bit_vld = 1'b0; cfg_bit = 1'b0;
    conv_start = 1'b0; conv_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({13'h0, chan_sel}, 16'h0, "R1 chan");
    chk({15'h0, temp_sel}, 16'h0, "R1 temp");
    chk({2'b00, cfg_readback}, 16'h0380, "R1 readback");

    conv(3'd0, 1'b0, "R4 default off");
    // fixed channel 5, sequencer off, other bits 0xA / 01
    send({mk(4'hA, 3'd2, 2'b01, 2'b00, 3'd5), 2'b00}, 14);
    conv(3'd5, 1'b0, "R2 commit");
    exp_rb(14'h2925, "R2 msb first");
    conv(3'd5, 1'b0, "R4 repeat");
    // partial word (10 strobes) must be dropped
    send({mk(4'h0, 3'd0, 2'b00, 2'b00, 3'd3), 2'b00}, 10);
    exp_sel(3'd5, 1'b0, "R10 hold");
    conv(3'd5, 1'b0, "R3 partial");
    exp_rb(14'h2925, "R3 partial rb");
    // scan channels only, last 2
    send({14'h011E, 2'b00}, 14);
    exp_rb(14'h2925, "R9 prev during write");
    conv(3'd0, 1'b0, "R7 restart");
    exp_rb(14'h011E, "R9 new");
    conv(3'd1, 1'b0, "R5 step1");
    conv(3'd2, 1'b0, "R5 step2");
    conv(3'd0, 1'b0, "R5 wrap");
    // channels then temperature, last 1
    send({14'h0090, 2'b00}, 14);
    conv(3'd0, 1'b0, "R7 restart temp");
    conv(3'd1, 1'b0, "R6 ch1");
    conv(3'd0, 1'b1, "R6 temp");
    conv(3'd0, 1'b0, "R6 wrap");
    conv(3'd1, 1'b0, "R6 ch1b");
    // update mode: last 3, other 0x3; position (temp) kept
    send({14'h0D88, 2'b00}, 14);
    conv(3'd0, 1'b1, "R8 keep temp");
    exp_rb(14'h0D90, "R8 mode kept");
    conv(3'd0, 1'b0, "R8 wrap");
    conv(3'd1, 1'b0, "R8 ch1");
    conv(3'd2, 1'b0, "R8 ch2");
    // update mode: last 1, pointer 3 beyond it
    send({14'h0C88, 2'b00}, 14);
    conv(3'd0, 1'b0, "R8 beyond last");
    conv(3'd1, 1'b0, "R8 after");
    conv(3'd0, 1'b1, "R8 temp again");
    conv(3'd0, 1'b0, "R6 wrap2");
    // 16 strobes: last two ignored
    send({14'h145F, 2'b11}, 16);
    conv(3'd0, 1'b0, "R3 extra ignored");
    conv(3'd0, 1'b0, "R5 single channel");
    exp_rb(14'h145F, "R3 extra rb");
    // back to fixed channel 3
    send({14'h0383, 2'b00}, 14);
    conv(3'd3, 1'b0, "R4 fixed3");
    conv(3'd3, 1'b0, "R4 fixed3 again");
    exp_rb(14'h0383, "R2 final");
    repeat (3) @(negedge clk);
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule